// File: doc/BRIEF.md
# Asynchronous SRAM Write Controller

This block turns single-beat write requests into correctly timed strobe sequences for a 16-bit asynchronous static RAM. A client presents an address, sixteen bits of data, a two-bit lane mask and a style bit on a valid/ready handshake. The controller captures the request and holds the address and data on the memory buses. It then walks a fixed phase sequence: setup, bus turnaround, data pulse, hold and an optional pad. It drives active-low chip enable, write enable and two byte-lane selects as registered outputs, so the strobes cannot glitch.

Every timing minimum is given as a parameter in picoseconds, together with the clock period. Each phase length is derived by rounding up to whole cycles. The turnaround phase keeps the controller's data drivers off until the memory's output has had time to float. The drivers are switched off on the same edge that ends the write. Two write styles are offered per request. In one, write enable opens and closes the write. In the other, write enable goes low first and stays low past the end, and chip enable bounds the write.

Top module: `sram_wr_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, req_ready is 1, mem_ce_n, mem_we_n, mem_lb_n and mem_ub_n are 1 and mem_dq_oe is 0.
- R2: A request is accepted on a rising edge where req_valid and req_ready are both 1. req_ready then reads 0 for exactly BUSY cycles, where BUSY = max(ceil(CYCLE_PS/CLK_PS), S+T+P+H), and is 1 again in the cycle after.
- R3: When req_ce_style = 0, counting the first cycle after acceptance as index 0: mem_ce_n is low for indices 0 to S+T+P-1, and mem_we_n is low for indices S to S+T+P-1. The write therefore ends with write enable rising on the same edge as chip enable.
- R4: When req_ce_style = 1, mem_we_n is low for indices 0 to S+T+P+H-1, and mem_ce_n is low only for indices S to S+T+P-1. The write therefore ends with chip enable rising while write enable is still low.
- R5: req_mask bit 0 selects the low lane (data bits 7:0, mem_lb_n) and bit 1 selects the high lane (bits 15:8, mem_ub_n). A lane's select is low only while its mask bit is 1 and chip enable is low. It is low for indices 0 to S+T+P-1 in style 0 and for indices S to S+T+P-1 in style 1. A lane with mask bit 0 is never written.
- R6: mem_dq_oe is 1 only for indices S+T to S+T+P-1. This is only after chip and write enable have both been low for T cycles, and it drops on the edge that ends the write.
- R7: mem_addr and mem_dq_o take the request's address and data from index 0 and stay unchanged until req_ready returns.
- R8: S, T, P and H are ceil(ps/CLK_PS) with a floor of 1 for setup, turnaround, hold and data-valid. P is the largest of the data-valid count, the write-pulse count minus T, and the chip-enable-low count minus T. The resulting write window meets the write pulse, chip-enable and byte-select minimums, and the data-valid minimum.
- R9: A synchronous reset raised during a write cycle returns all strobes high, mem_dq_oe low and req_ready high on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_addr | input | ADDR_W | Word address of the write |
| req_data | input | 16 | Write data, two byte lanes |
| req_mask | input | 2 | Lane enables, bit 0 low byte, bit 1 high byte |
| req_ce_style | input | 1 | 0: write enable bounds the write, 1: chip enable bounds it |
| mem_addr | output | ADDR_W | Address bus to the memory |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Low byte select, active low |
| mem_ub_n | output | 1 | High byte select, active low |
| mem_dq_o | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Data driver enable |

## Verification
A wrong phase or counter value shows up within one cycle as a strobe edge at the wrong index after acceptance. It can also show as req_ready returning early or late. A corrupt style or mask capture shows up as the wrong strobe bounding the write, or as a select low on a lane that should stay idle, already at index 0 or S. The bench's memory model turns these into short windows, early driver enables and wrong stored bytes, which are checked at the end of each write.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SETUP = 3'd1,
        PH_TURN  = 3'd2,
        PH_PULSE = 3'd3,
        PH_HOLD  = 3'd4,
        PH_PAD   = 3'd5
    } phase_e;

    typedef enum logic {
        STYLE_WE = 1'b0,
        STYLE_CE = 1'b1
    } style_e;

    typedef struct packed {
        logic       ce_n;
        logic       we_n;
        logic [1:0] sel_n;   // [0] low lane, [1] high lane
        logic       oe;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{ce_n: 1'b1, we_n: 1'b1, sel_n: 2'b11, oe: 1'b0};

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // whole cycles covering a duration, never less than one
    function automatic int ceil_cycles(input int dur_ps, input int clk_ps);
        int c;
        c = (dur_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/sram_wr_seq.sv
module sram_wr_seq
    import sram_wr_pkg::*;
#(
    parameter int N_SETUP = 1,
    parameter int N_TURN  = 1,
    parameter int N_PULSE = 1,
    parameter int N_HOLD  = 1,
    parameter int N_PAD   = 0
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    output phase_e phase_q,
    output phase_e phase_d
);
    localparam int NMAX  = imax(imax(imax(N_SETUP, N_TURN), imax(N_PULSE, N_HOLD)), imax(N_PAD, 1));
    localparam int CNT_W = $clog2(NMAX + 1);

    localparam logic [CNT_W-1:0] L_SETUP = CNT_W'(N_SETUP - 1);
    localparam logic [CNT_W-1:0] L_TURN  = CNT_W'(N_TURN - 1);
    localparam logic [CNT_W-1:0] L_PULSE = CNT_W'(N_PULSE - 1);
    localparam logic [CNT_W-1:0] L_HOLD  = CNT_W'(N_HOLD - 1);
    localparam logic [CNT_W-1:0] L_PAD   = CNT_W'(imax(N_PAD, 1) - 1);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             last;

    function automatic logic [CNT_W-1:0] span(input phase_e p);
        case (p)
            PH_SETUP: return L_SETUP;
            PH_TURN:  return L_TURN;
            PH_PULSE: return L_PULSE;
            PH_HOLD:  return L_HOLD;
            PH_PAD:   return L_PAD;
            default:  return '0;
        endcase
    endfunction

    assign last = (cnt_q == '0);

    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_IDLE:  if (start) phase_d = PH_SETUP;
            PH_SETUP: if (last)  phase_d = PH_TURN;
            PH_TURN:  if (last)  phase_d = PH_PULSE;
            PH_PULSE: if (last)  phase_d = PH_HOLD;
            PH_HOLD:  if (last)  phase_d = (N_PAD > 0) ? PH_PAD : PH_IDLE;
            PH_PAD:   if (last)  phase_d = PH_IDLE;
            default:             phase_d = PH_IDLE;
        endcase
    end

    always_comb begin
        if (phase_d != phase_q) cnt_d = span(phase_d);
        else if (!last)         cnt_d = cnt_q - 1'b1;
        else                    cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    // R2: a phase never outlasts its own count
    assert_count_bound_R2: assert property (@(posedge clk) disable iff (rst)
        (phase_q != PH_IDLE && last) |=> (phase_q != $past(phase_q)));

endmodule

// File: rtl/sram_wr_strobe.sv
module sram_wr_strobe
    import sram_wr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  phase_e     phase_d,
    input  style_e     style,
    input  logic [1:0] mask,
    output strobe_t    q
);
    strobe_t s;

    always_comb begin
        s = STROBE_IDLE;
        case (phase_d)
            PH_SETUP: begin
                if (style == STYLE_WE) begin
                    s.ce_n  = 1'b0;
                    s.sel_n = ~mask;
                end else begin
                    s.we_n  = 1'b0;
                end
            end
            PH_TURN: begin
                s.ce_n  = 1'b0;
                s.we_n  = 1'b0;
                s.sel_n = ~mask;
            end
            PH_PULSE: begin
                s.ce_n  = 1'b0;
                s.we_n  = 1'b0;
                s.sel_n = ~mask;
                s.oe    = 1'b1;
            end
            PH_HOLD: begin
                if (style == STYLE_CE) s.we_n = 1'b0;
            end
            default: s = STROBE_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= STROBE_IDLE;
        else     q <= s;
    end

    // R6: drivers only inside the write window
    assert_oe_window_R6: assert property (@(posedge clk) disable iff (rst)
        q.oe |-> (!q.ce_n && !q.we_n));

    // R6: turnaround cycle precedes the drivers
    assert_oe_turn_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(q.oe) |-> ($past(q.ce_n) == 1'b0 && $past(q.we_n) == 1'b0));

    // R5: a lane select needs chip enable
    assert_sel_needs_ce_R5: assert property (@(posedge clk) disable iff (rst)
        (q.sel_n != 2'b11) |-> !q.ce_n);

endmodule

// File: rtl/sram_wr_ctrl.sv
module sram_wr_ctrl
    import sram_wr_pkg::*;
#(
    parameter int ADDR_W    = 18,
    parameter int CLK_PS    = 10000,
    parameter int SETUP_PS  = 0,
    parameter int TURN_PS   = 6000,
    parameter int DATA_PS   = 5000,
    parameter int WPULSE_PS = 7000,
    parameter int CELOW_PS  = 8000,
    parameter int HOLD_PS   = 0,
    parameter int CYCLE_PS  = 10000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_data,
    input  logic [1:0]        req_mask,
    input  logic              req_ce_style,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_lb_n,
    output logic              mem_ub_n,
    output logic [15:0]       mem_dq_o,
    output logic              mem_dq_oe
);
    localparam int N_SETUP = ceil_cycles(SETUP_PS, CLK_PS);
    localparam int N_TURN  = ceil_cycles(TURN_PS, CLK_PS);
    localparam int N_PULSE = imax(ceil_cycles(DATA_PS, CLK_PS),
                                  imax(ceil_cycles(WPULSE_PS, CLK_PS) - N_TURN,
                                       ceil_cycles(CELOW_PS, CLK_PS) - N_TURN));
    localparam int N_HOLD  = ceil_cycles(HOLD_PS, CLK_PS);
    localparam int N_SUM   = N_SETUP + N_TURN + N_PULSE + N_HOLD;
    localparam int N_PAD   = imax(0, ceil_cycles(CYCLE_PS, CLK_PS) - N_SUM);

    phase_e     phase_q, phase_d;
    strobe_t    strb;
    style_e     style_q, style_d;
    logic [1:0] mask_q, mask_d;
    logic       accept;

    assign req_ready = (phase_q == PH_IDLE);
    assign accept    = req_valid && req_ready;
    assign style_d   = accept ? style_e'(req_ce_style) : style_q;
    assign mask_d    = accept ? req_mask : mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            style_q  <= STYLE_WE;
            mask_q   <= 2'b00;
            mem_addr <= '0;
            mem_dq_o <= '0;
        end else if (accept) begin
            style_q  <= style_d;
            mask_q   <= mask_d;
            mem_addr <= req_addr;
            mem_dq_o <= req_data;
        end
    end

    sram_wr_seq #(
        .N_SETUP (N_SETUP),
        .N_TURN  (N_TURN),
        .N_PULSE (N_PULSE),
        .N_HOLD  (N_HOLD),
        .N_PAD   (N_PAD)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (accept),
        .phase_q (phase_q),
        .phase_d (phase_d)
    );

    sram_wr_strobe u_strobe (
        .clk     (clk),
        .rst     (rst),
        .phase_d (phase_d),
        .style   (style_d),
        .mask    (mask_d),
        .q       (strb)
    );

    assign mem_ce_n  = strb.ce_n;
    assign mem_we_n  = strb.we_n;
    assign mem_lb_n  = strb.sel_n[0];
    assign mem_ub_n  = strb.sel_n[1];
    assign mem_dq_oe = strb.oe;

    // R2: acceptance closes the handshake
    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
        accept |=> !req_ready);

    // R7: buses frozen while busy
    assert_bus_stable_R7: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && !$past(req_ready)) |-> ($stable(mem_addr) && $stable(mem_dq_o)));

    // R9 (and R1): first cycle out of reset is idle
    assert_reset_idle_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (req_ready && mem_ce_n && mem_we_n && mem_lb_n && mem_ub_n && !mem_dq_oe));

endmodule

// File: tb/sram_wr_ctrl_bench.sv
module sram_wr_ctrl_bench;

    localparam int CLK_PS    = 10000;
    localparam int TURN_PS   = 12000;
    localparam int CYCLE_PS  = 70000;
    // phase lengths worked out by hand from R8 for these settings
    localparam int S = 1, T = 2, P = 1, H = 1;
    localparam int BUSY = 7;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [17:0] req_addr = '0;
    logic [15:0] req_data = '0;
    logic [1:0]  req_mask = '0;
    logic        req_ce_style = 1'b0;
    logic [17:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe;
    logic [15:0] mem_dq_o;

    int total = 0;
    int bad   = 0;
    int viol  = 0;
    bit done  = 1'b0;

    always #5ns clk = ~clk;

    sram_wr_ctrl #(
        .ADDR_W   (18),
        .CLK_PS   (CLK_PS),
        .TURN_PS  (TURN_PS),
        .CYCLE_PS (CYCLE_PS)
    ) u_sram_wr_ctrl (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_addr     (req_addr),
        .req_data     (req_data),
        .req_mask     (req_mask),
        .req_ce_style (req_ce_style),
        .mem_addr     (mem_addr),
        .mem_ce_n     (mem_ce_n),
        .mem_we_n     (mem_we_n),
        .mem_lb_n     (mem_lb_n),
        .mem_ub_n     (mem_ub_n),
        .mem_dq_o     (mem_dq_o),
        .mem_dq_oe    (mem_dq_oe)
    );

    // ---------------- memory model with timing checks (R5, R6, R8)
    logic [15:0] mdl_mem [64] = '{default: 16'h0000};
    logic [15:0] exp_mem [64] = '{default: 16'h0000};
    int          win_cnt = 0;
    int          oe_cnt  = 0;
    logic [5:0]  w_addr;
    logic [1:0]  w_sel;
    logic [15:0] w_data;

    always @(negedge clk) begin
        automatic bit win = !mem_ce_n && !mem_we_n;
        if (rst) begin
            win_cnt = 0;
            oe_cnt  = 0;
        end else begin
            if (mem_dq_oe && !win) viol++;
            if (mem_dq_oe && win && win_cnt * CLK_PS < 6000) viol++;
            if ((!mem_lb_n || !mem_ub_n) && mem_ce_n) viol++;
            if (win) begin
                if (win_cnt > 0 && mem_addr[5:0] != w_addr) viol++;
                w_addr = mem_addr[5:0];
                w_sel  = {mem_ub_n, mem_lb_n};
                if (mem_dq_oe) w_data = mem_dq_o;
                win_cnt++;
                if (mem_dq_oe) oe_cnt++;
            end else if (win_cnt > 0) begin
                if (win_cnt * CLK_PS < 7000) viol++;
                if (win_cnt * CLK_PS < 8000) viol++;
                if (oe_cnt * CLK_PS < 5000) viol++;
                if (!w_sel[0]) mdl_mem[w_addr][7:0]  = w_data[7:0];
                if (!w_sel[1]) mdl_mem[w_addr][15:8] = w_data[15:8];
                win_cnt = 0;
                oe_cnt  = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // one request started at a negedge with req_ready high, traced for BUSY+1 cycles
    task automatic run_req(input logic st, input logic [1:0] m, input logic [5:0] a, input logic [15:0] d);
        logic       tr_ce  [BUSY+1];
        logic       tr_we  [BUSY+1];
        logic [1:0] tr_sel [BUSY+1];
        logic       tr_oe  [BUSY+1];
        logic       tr_rdy [BUSY+1];
        logic [17:0] tr_a  [BUSY+1];
        logic [15:0] tr_d  [BUSY+1];
        int v0;
        v0 = viol;
        chk(req_ready == 1'b1, "R2 ready before request", 32'(req_ready), 32'd1);
        req_valid    = 1'b1;
        req_ce_style = st;
        req_mask     = m;
        req_addr     = {12'h000, a};
        req_data     = d;
        @(negedge clk);
        req_valid = 1'b0;
        req_data  = ~d;
        req_addr  = 18'h3ffff;
        for (int k = 0; k <= BUSY; k++) begin
            tr_ce[k]  = mem_ce_n;
            tr_we[k]  = mem_we_n;
            tr_sel[k] = {mem_ub_n, mem_lb_n};
            tr_oe[k]  = mem_dq_oe;
            tr_rdy[k] = req_ready;
            tr_a[k]   = mem_addr;
            tr_d[k]   = mem_dq_o;
            if (k < BUSY) @(negedge clk);
        end
        for (int k = 0; k <= BUSY; k++) begin
            automatic bit ce_lo  = st ? (k >= S && k < S+T+P) : (k < S+T+P);
            automatic bit we_lo  = st ? (k < S+T+P+H) : (k >= S && k < S+T+P);
            automatic bit sel_on = st ? ce_lo : (k < S+T+P);
            automatic bit oe_on  = (k >= S+T && k < S+T+P);
            automatic logic [1:0] sel_e = sel_on ? ~m : 2'b11;
            chk(tr_rdy[k] == (k >= BUSY), "R2 ready trace", 32'(tr_rdy[k]), 32'(k >= BUSY));
            if (st) begin
                chk(tr_ce[k] == !ce_lo, "R4 ce_n trace", 32'(tr_ce[k]), 32'(!ce_lo));
                chk(tr_we[k] == !we_lo, "R4 we_n trace", 32'(tr_we[k]), 32'(!we_lo));
            end else begin
                chk(tr_ce[k] == !ce_lo, "R3 ce_n trace", 32'(tr_ce[k]), 32'(!ce_lo));
                chk(tr_we[k] == !we_lo, "R3 we_n trace", 32'(tr_we[k]), 32'(!we_lo));
            end
            chk(tr_sel[k] == sel_e, "R5 lane select trace", 32'(tr_sel[k]), 32'(sel_e));
            chk(tr_oe[k] == oe_on, "R6 driver enable trace", 32'(tr_oe[k]), 32'(oe_on));
            if (k < BUSY) begin
                chk(tr_a[k] == {12'h000, a}, "R7 address held", 32'(tr_a[k]), 32'(a));
                chk(tr_d[k] == d, "R7 data held", 32'(tr_d[k]), 32'(d));
            end
        end
        if (m[0]) exp_mem[a][7:0]  = d[7:0];
        if (m[1]) exp_mem[a][15:8] = d[15:8];
        chk(mdl_mem[a] == exp_mem[a], "R5 stored lanes", 32'(mdl_mem[a]), 32'(exp_mem[a]));
        chk(viol == v0, "R8 timing minimums", 32'(viol - v0), 32'd0);
    endtask

    // {style, mask[1:0], addr[5:0], data[15:0]}
    localparam logic [24:0] VEC [8] = '{
        {1'b0, 2'b11, 6'd5, 16'hA55A},
        {1'b0, 2'b01, 6'd5, 16'h1234},
        {1'b0, 2'b10, 6'd5, 16'hBEEF},
        {1'b1, 2'b11, 6'd9, 16'hC3C3},
        {1'b1, 2'b00, 6'd9, 16'hFFFF},
        {1'b1, 2'b10, 6'd9, 16'h0F0F},
        {1'b0, 2'b00, 6'd2, 16'h7777},
        {1'b1, 2'b01, 6'd2, 16'h0055}
    };

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(req_ready == 1'b1, "R1 ready in reset", 32'(req_ready), 32'd1);
        chk({mem_ce_n, mem_we_n, mem_ub_n, mem_lb_n} == 4'hF, "R1 strobes high in reset",
            32'({mem_ce_n, mem_we_n, mem_ub_n, mem_lb_n}), 32'hF);
        chk(mem_dq_oe == 1'b0, "R1 drivers off in reset", 32'(mem_dq_oe), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk({req_ready, mem_ce_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe} == 6'b111110,
            "R1 idle after reset", 32'({req_ready, mem_ce_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe}), 32'h3E);

        // table walk: back-to-back requests, both styles, all masks (R2..R8)
        for (int i = 0; i < 8; i++) begin
            run_req(VEC[i][24], VEC[i][23:22], VEC[i][21:16], VEC[i][15:0]);
        end

        // R5: masked-off lanes leave earlier contents untouched
        chk(mdl_mem[5] == 16'hBE34, "R5 lane merge addr5", 32'(mdl_mem[5]), 32'hBE34);
        chk(mdl_mem[9] == 16'h0FC3, "R5 lane merge addr9", 32'(mdl_mem[9]), 32'h0FC3);
        chk(mdl_mem[2] == 16'h0055, "R5 lane merge addr2", 32'(mdl_mem[2]), 32'h0055);

        // R9: reset in the middle of a write
        req_valid = 1'b1; req_ce_style = 1'b0; req_mask = 2'b11;
        req_addr = 18'd12; req_data = 16'hDEAD;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk({req_ready, mem_ce_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe} == 6'b111110,
            "R9 abort to idle", 32'({req_ready, mem_ce_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe}), 32'h3E);
        rst = 1'b0;
        @(negedge clk);
        chk(mdl_mem[12] == 16'h0000, "R9 aborted write stores nothing", 32'(mdl_mem[12]), 32'h0);
        run_req(1'b1, 2'b11, 6'd12, 16'h5A5A);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule